// File: doc/BRIEF.md
# Byte-Wide Board Peripheral Address Decoder

This block sits between a processor bus and a group of byte-wide board devices. For every request it decodes the 32-bit address and produces at most one chip select. The select goes to one of three boot ROM slots, an EEPROM stable store, a battery-backed RAM, a real-time-clock/status port or a front-panel latch. It also produces the device-local address or byte index for that select. Every transfer moves a single byte on data bits 7:0. Splitting wider bus transactions into bytes is done upstream.

The boot ROM appears in two places. The primary window at 0x1F00_0000 reaches every byte. A sparse alias at 0xF000_0000 answers only on word-aligned addresses. The peripherals live at 0xF004_0000 to 0xF007_FFFF, one 64 KB region each, and the small devices alias throughout their region. A read-only mirror of the peripherals at 0x1F04_0000 accepts reads and drops writes. A strap input chooses between 64 KB and 128 KB ROM devices.

The EEPROM needs a long time to finish a write, so the block times that busy period in hardware. While the period runs, the block refuses stable-store accesses and flags each refused access. The busy state is reported, together with three board signals, in the status nibble that comes back with clock-port reads.

Top module: `board_addr_decoder`

## Requirements
- R1: With the ROM strap high (128 KB devices), a request in 0x1F00_0000..0x1F03_FFFF selects ROM slot addr[17] (rom_cs_o bit index) for both reads and writes-excluded reads, with rom_addr_o = addr[16:0].
- R2: With the strap low (64 KB devices), the ROM slot is addr[17:16]. Slot 3 selects nothing, and rom_addr_o = {0, addr[15:0]}.
- R3: A read in 0xF000_0000..0xF003_FFFF selects the ROM exactly as R1/R2 only when addr[1:0] = 00. Any other low bits select nothing.
- R4: A write request never asserts any rom_cs_o bit.
- R5: A request in 0xF004_0000..0xF007_FFFF selects by addr[17:16]: 00 stable store, 01 battery RAM, 10 clock/status, 11 front-panel latch. All other address bits alias within the region. we_o is high exactly when a peripheral is selected by a write.
- R6: mem_idx_o equals addr[14:2] and rtc_idx_o equals addr[5:2], so one device byte occupies each 4-byte address step.
- R7: In the mirror window 0x1F04_0000..0x1F07_FFFF, reads decode as in R5. Writes assert no select and keep we_o low.
- R8: At most one select is active at a time. With req_i low, or with an address outside every window, no select is active.
- R9: A stable-store write that is forwarded makes ss_busy_o high for exactly BUSY_CYCLES cycles, starting on the clock edge that takes the write.
- R10: While ss_busy_o is high, a stable-store request asserts no ss_cs_o and drives busy_err_o high in that cycle. Requests to the other regions proceed and leave busy_err_o low.
- R11: status_o holds the clock nibble on bits 7:4. Bit 0 is stable store busy, bit 1 is the inverse of pwr_fail_ni, bit 2 is diag_en_i, and bit 3 is the inverse of sec_fail_ni.
- R12: Writes to the clock/status region leave the status bits unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Byte access request valid |
| we_i | input | 1 | Request is a write |
| addr_i | input | 32 | Byte address |
| rom_big_i | input | 1 | ROM size strap, 1 = 128 KB devices |
| pwr_fail_ni | input | 1 | Power-fail, active low |
| sec_fail_ni | input | 1 | Secondary-fail, active low |
| diag_en_i | input | 1 | Remote-diagnostic enable line |
| rtc_nib_i | input | 4 | Nibble read from the clock chip |
| rom_cs_o | output | ROM_SLOTS | One-hot ROM slot select |
| rom_addr_o | output | 17 | Address within the selected ROM |
| ss_cs_o | output | 1 | Stable-store select |
| nv_cs_o | output | 1 | Battery RAM select |
| rtc_cs_o | output | 1 | Clock/status port select |
| led_cs_o | output | 1 | Front-panel latch select |
| we_o | output | 1 | Write strobe to the selected peripheral |
| mem_idx_o | output | MEM_IDX_W | Byte index for stable store and battery RAM |
| rtc_idx_o | output | RTC_IDX_W | Clock-chip register index |
| status_o | output | 8 | Clock nibble plus status bits |
| ss_busy_o | output | 1 | Stable store busy |
| busy_err_o | output | 1 | Stable-store access refused while busy |

## Verification
The assertions check several properties on every cycle. At most one select is active. Mirror-window writes and ROM writes select nothing, and alias-window accesses with nonzero low bits select nothing. A forwarded stable-store write is followed by busy, no stable-store select appears during busy, and every status bit tracks its source. Other behaviours only the bench scenarios can show. These are the exact ROM slot and device address under each strap, the index fields, the peripheral aliasing and the exact length of the busy window. They also include the behaviour of non-stable-store regions during busy, and status stability across clock-region writes.

// File: rtl/bpd_pkg.sv
package bpd_pkg;
  typedef enum logic [1:0] {
    RG_STABLE = 2'd0,
    RG_NVRAM  = 2'd1,
    RG_CLOCK  = 2'd2,
    RG_PANEL  = 2'd3
  } periph_e;

  localparam int unsigned TAG_LSB = 18;
  localparam logic [13:0] ROM_MAIN_TAG   = 14'h07C0;
  localparam logic [13:0] ROM_ALIAS_TAG  = 14'h3C00;
  localparam logic [13:0] PER_MAIN_TAG   = 14'h3C01;
  localparam logic [13:0] PER_MIRROR_TAG = 14'h07C1;
endpackage

// File: rtl/bpd_rom_map.sv
module bpd_rom_map #(
  parameter int unsigned SLOTS = 3
) (
  input  logic             hit_i,
  input  logic             big_i,
  input  logic [17:0]      off_i,
  output logic [SLOTS-1:0] cs_o,
  output logic [16:0]      dev_addr_o
);
  logic [1:0] slot;

  assign slot       = big_i ? {1'b0, off_i[17]} : off_i[17:16];
  assign dev_addr_o = big_i ? off_i[16:0] : {1'b0, off_i[15:0]};

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    assign cs_o[g] = hit_i && (slot == 2'(g));
  end
endmodule

// File: rtl/bpd_periph_map.sv
module bpd_periph_map
  import bpd_pkg::*;
(
  input  logic       hit_i,
  input  logic [1:0] sel_i,
  input  logic       ss_block_i,
  output logic [3:0] cs_o,
  output logic       err_o
);
  for (genvar g = 0; g < 4; g++) begin : g_rgn
    if (g == int'(RG_STABLE)) begin : g_ss
      assign cs_o[g] = hit_i && (sel_i == RG_STABLE) && !ss_block_i;
    end else begin : g_other
      assign cs_o[g] = hit_i && (sel_i == 2'(g));
    end
  end

  assign err_o = hit_i && (sel_i == RG_STABLE) && ss_block_i;
endmodule

// File: rtl/bpd_busy_timer.sv
module bpd_busy_timer #(
  parameter int unsigned CYCLES = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o
);
  localparam int unsigned CW = $clog2(CYCLES + 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (start_i)       cnt_q <= CW'(CYCLES);
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/board_addr_decoder.sv
module board_addr_decoder
  import bpd_pkg::*;
#(
  parameter int unsigned ROM_SLOTS   = 3,
  parameter int unsigned BUSY_CYCLES = 64,
  parameter int unsigned MEM_IDX_W   = 13,
  parameter int unsigned RTC_IDX_W   = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 req_i,
  input  logic                 we_i,
  input  logic [31:0]          addr_i,
  input  logic                 rom_big_i,
  input  logic                 pwr_fail_ni,
  input  logic                 sec_fail_ni,
  input  logic                 diag_en_i,
  input  logic [3:0]           rtc_nib_i,
  output logic [ROM_SLOTS-1:0] rom_cs_o,
  output logic [16:0]          rom_addr_o,
  output logic                 ss_cs_o,
  output logic                 nv_cs_o,
  output logic                 rtc_cs_o,
  output logic                 led_cs_o,
  output logic                 we_o,
  output logic [MEM_IDX_W-1:0] mem_idx_o,
  output logic [RTC_IDX_W-1:0] rtc_idx_o,
  output logic [7:0]           status_o,
  output logic                 ss_busy_o,
  output logic                 busy_err_o
);
  logic [13:0] tag;
  logic        rom_hit, per_hit, per_any;
  logic [3:0]  per_cs;

  assign tag = addr_i[31:TAG_LSB];

  // alias window reaches only word-aligned bytes; ROM never takes writes
  assign rom_hit = req_i && !we_i &&
                   ((tag == ROM_MAIN_TAG) ||
                    (tag == ROM_ALIAS_TAG && addr_i[1:0] == 2'b00));

  // mirror window is read-only
  assign per_hit = req_i && ((tag == PER_MAIN_TAG) ||
                             (tag == PER_MIRROR_TAG && !we_i));

  bpd_rom_map #(.SLOTS(ROM_SLOTS)) u_rom (
    .hit_i      (rom_hit),
    .big_i      (rom_big_i),
    .off_i      (addr_i[17:0]),
    .cs_o       (rom_cs_o),
    .dev_addr_o (rom_addr_o)
  );

  bpd_periph_map u_per (
    .hit_i      (per_hit),
    .sel_i      (addr_i[17:16]),
    .ss_block_i (ss_busy_o),
    .cs_o       (per_cs),
    .err_o      (busy_err_o)
  );

  bpd_busy_timer #(.CYCLES(BUSY_CYCLES)) u_busy (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (per_cs[RG_STABLE] && we_i),
    .busy_o  (ss_busy_o)
  );

  assign ss_cs_o  = per_cs[RG_STABLE];
  assign nv_cs_o  = per_cs[RG_NVRAM];
  assign rtc_cs_o = per_cs[RG_CLOCK];
  assign led_cs_o = per_cs[RG_PANEL];
  assign per_any  = |per_cs;
  assign we_o     = per_any && we_i;

  assign mem_idx_o = addr_i[MEM_IDX_W+1:2];
  assign rtc_idx_o = addr_i[RTC_IDX_W+1:2];

  assign status_o = {rtc_nib_i, ~sec_fail_ni, diag_en_i, ~pwr_fail_ni, ss_busy_o};
endmodule

// File: rtl/bpd_checker.sv
module bpd_checker #(
  parameter int unsigned ROM_SLOTS = 3
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 req_i,
  input logic                 we_i,
  input logic [31:0]          addr_i,
  input logic                 pwr_fail_ni,
  input logic                 sec_fail_ni,
  input logic                 diag_en_i,
  input logic [3:0]           rtc_nib_i,
  input logic [ROM_SLOTS-1:0] rom_cs_o,
  input logic                 ss_cs_o,
  input logic                 nv_cs_o,
  input logic                 rtc_cs_o,
  input logic                 led_cs_o,
  input logic                 we_o,
  input logic [7:0]           status_o,
  input logic                 ss_busy_o
);
  assert_single_select_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({rom_cs_o, ss_cs_o, nv_cs_o, rtc_cs_o, led_cs_o}));

  assert_mirror_write_blocked_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && addr_i[31:18] == 14'h07C1) |->
      !(ss_cs_o || nv_cs_o || rtc_cs_o || led_cs_o || we_o));

  assert_rom_no_write_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i) |-> (rom_cs_o == '0));

  assert_alias_lowbits_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i[31:18] == 14'h3C00 && addr_i[1:0] != 2'b00) |-> (rom_cs_o == '0));

  assert_busy_after_write_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ss_cs_o && we_o) |=> ss_busy_o);

  assert_blocked_when_busy_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ss_busy_o |-> !ss_cs_o);

  assert_status_bits_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o == {rtc_nib_i, !sec_fail_ni, diag_en_i, !pwr_fail_ni, ss_busy_o});
endmodule

bind board_addr_decoder bpd_checker #(.ROM_SLOTS(ROM_SLOTS)) u_bpd_checker (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_i       (req_i),
  .we_i        (we_i),
  .addr_i      (addr_i),
  .pwr_fail_ni (pwr_fail_ni),
  .sec_fail_ni (sec_fail_ni),
  .diag_en_i   (diag_en_i),
  .rtc_nib_i   (rtc_nib_i),
  .rom_cs_o    (rom_cs_o),
  .ss_cs_o     (ss_cs_o),
  .nv_cs_o     (nv_cs_o),
  .rtc_cs_o    (rtc_cs_o),
  .led_cs_o    (led_cs_o),
  .we_o        (we_o),
  .status_o    (status_o),
  .ss_busy_o   (ss_busy_o)
);

// File: tb/board_addr_decoder_tb_top.sv
`timescale 1ns/1ps
module board_addr_decoder_tb_top;
  localparam int unsigned NBUSY = 8;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0, we_i = 1'b0, rom_big_i = 1'b0;
  logic [31:0] addr_i = '0;
  logic        pwr_fail_ni = 1'b1, sec_fail_ni = 1'b1, diag_en_i = 1'b0;
  logic [3:0]  rtc_nib_i = 4'h0;
  logic [2:0]  rom_cs_o;
  logic [16:0] rom_addr_o;
  logic        ss_cs_o, nv_cs_o, rtc_cs_o, led_cs_o, we_o, ss_busy_o, busy_err_o;
  logic [12:0] mem_idx_o;
  logic [3:0]  rtc_idx_o;
  logic [7:0]  status_o;

  int n_chk = 0, n_fail = 0;

  always #2.5 clk_i = ~clk_i;

  board_addr_decoder #(.BUSY_CYCLES(NBUSY)) dut_i (.*);

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h addr=%h we=%0b big=%0b", req, act, exp, addr_i, we_i, rom_big_i);
    end
  endtask

  // expected decode computed from the requirements
  task automatic sweep_one(input logic [31:0] a, input bit w, input bit big);
    logic [13:0] t;
    logic [2:0]  e_rom;
    logic [16:0] e_radr;
    logic [3:0]  e_per;
    logic        e_we;
    logic [1:0]  slot;
    string       tag;
    t = a[31:18]; e_rom = '0; e_per = '0; tag = "R8";
    slot   = big ? {1'b0, a[17]} : a[17:16];
    e_radr = big ? a[16:0] : {1'b0, a[15:0]};
    if (t == 14'h07C0 || t == 14'h3C00) begin
      tag = w ? "R4" : (t == 14'h3C00 ? "R3" : (big ? "R1" : "R2"));
      if (!w && (t == 14'h07C0 || a[1:0] == 2'b00) && slot != 2'd3) e_rom[slot] = 1'b1;
    end
    if (t == 14'h3C01 || t == 14'h07C1) begin
      tag = (t == 14'h07C1) ? "R7" : "R5";
      if (!(t == 14'h07C1 && w)) e_per[a[17:16]] = 1'b1;
    end
    e_we = w && (e_per != 0);
    addr_i = a; we_i = w; rom_big_i = big; req_i = 1'b1;
    #1;
    chk(rom_cs_o == e_rom && (e_rom == 0 || rom_addr_o == e_radr), tag,
        {rom_cs_o, rom_addr_o}, {e_rom, e_radr});
    chk({led_cs_o, rtc_cs_o, nv_cs_o, ss_cs_o} == e_per && we_o == e_we, tag,
        {led_cs_o, rtc_cs_o, nv_cs_o, ss_cs_o, we_o}, {e_per, e_we});
    if (e_per != 0)
      chk(mem_idx_o == a[14:2] && rtc_idx_o == a[5:2], "R6", {mem_idx_o, rtc_idx_o}, {a[14:2], a[5:2]});
  endtask

  initial begin : watchdog
    #(200000 * 5);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin : stim
    logic [15:0] ups [18];
    logic [15:0] lows [8];
    int busy_n;
    ups  = '{16'h1F00, 16'h1F01, 16'h1F02, 16'h1F03, 16'h1F04, 16'h1F05, 16'h1F06, 16'h1F07,
             16'hF000, 16'hF001, 16'hF002, 16'hF003, 16'hF004, 16'hF005, 16'hF006, 16'hF007,
             16'h1F08, 16'h0000};
    lows = '{16'h0000, 16'h0001, 16'h0002, 16'h0003, 16'h5A4C, 16'hFFFC, 16'hFFFF, 16'h1236};

    #12;
    chk(ss_busy_o == 1'b0 && status_o[0] == 1'b0, "R9", ss_busy_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R8: no request, no select
    addr_i = 32'hF006_0000; req_i = 1'b0; #1;
    chk({rom_cs_o, ss_cs_o, nv_cs_o, rtc_cs_o, led_cs_o, we_o} == 0, "R8", rom_cs_o, 0);

    // sweep: windows x offsets x strap x direction, skipping forwarded stable-store writes
    for (int b = 0; b < 2; b++)
      for (int w = 0; w < 2; w++)
        for (int u = 0; u < 18; u++)
          for (int l = 0; l < 8; l++) begin
            if (!(w == 1 && ups[u] == 16'hF004)) begin
              @(negedge clk_i);
              sweep_one({ups[u], lows[l]}, w[0], b[0]);
            end
          end
    @(negedge clk_i); req_i = 1'b0; we_i = 1'b0;

    // R11: status composition under all board-signal combinations
    for (int s = 0; s < 16; s++) begin
      @(negedge clk_i);
      pwr_fail_ni = s[0]; diag_en_i = s[1]; sec_fail_ni = s[2]; rtc_nib_i = 4'(s * 5);
      #1;
      chk(status_o == {4'(s * 5), ~s[2], s[1], ~s[0], 1'b0}, "R11", status_o,
          {4'(s * 5), ~s[2], s[1], ~s[0], 1'b0});
    end

    // R12: clock-region writes leave status unchanged
    for (int k = 0; k < 4; k++) begin
      @(negedge clk_i);
      req_i = 1'b1; we_i = 1'b1; addr_i = 32'hF006_0000 + 32'(k * 4);
      #1;
      chk(rtc_cs_o && we_o, "R12", rtc_cs_o, 1);
      @(negedge clk_i); req_i = 1'b0; we_i = 1'b0; #1;
      chk(status_o == {rtc_nib_i, ~sec_fail_ni, diag_en_i, ~pwr_fail_ni, 1'b0}, "R12", status_o,
          {rtc_nib_i, ~sec_fail_ni, diag_en_i, ~pwr_fail_ni, 1'b0});
    end

    // R9/R10: busy window after a stable-store write
    for (int rep = 0; rep < 2; rep++) begin
      @(negedge clk_i);
      req_i = 1'b1; we_i = 1'b1; addr_i = 32'hF004_0010 + 32'(rep * 32'h40);
      #1;
      chk(ss_cs_o && we_o && !busy_err_o, "R9", {ss_cs_o, we_o}, 2'b11);
      busy_n = 0;
      @(negedge clk_i);
      req_i = 1'b1; we_i = 1'b0; addr_i = 32'hF004_0020; #1;
      chk(!ss_cs_o && busy_err_o && status_o[0], "R10", {ss_cs_o, busy_err_o, status_o[0]}, 3'b011);
      addr_i = 32'h1F04_0024; we_i = 1'b1; #0.2;
      chk(!ss_cs_o && !we_o, "R10", {ss_cs_o, we_o}, 0);
      addr_i = 32'hF005_0008; we_i = 1'b0; #0.2;
      chk(nv_cs_o && !busy_err_o, "R10", {nv_cs_o, busy_err_o}, 2'b10);
      req_i = 1'b0;
      while (ss_busy_o && busy_n < 4 * NBUSY) begin
        busy_n++;
        @(negedge clk_i); #1;
      end
      chk(busy_n == NBUSY, "R9", 64'(busy_n), 64'(NBUSY));
      req_i = 1'b1; we_i = 1'b0; addr_i = 32'hF004_0020; #0.2;
      chk(ss_cs_o && !busy_err_o, "R10", {ss_cs_o, busy_err_o}, 2'b10);
      req_i = 1'b0;
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule